// File: doc/BRIEF.md
# Neural Crossbar Scheduler

This block decides which queued packets cross an N-port crossbar switch in the next switch cycle. It receives a square request matrix: bit `i*N+j` set means input `i` holds a packet for output `j`. It returns a grant matrix in the same encoding. The grant matrix never gives any input or any output more than one connection.

The choice comes from a square array of digital neurons, one per crosspoint. Every neuron holds a signed 12-bit state. Requested neurons start at half of coefficient C and unrequested neurons are parked at the most negative value. On each step, every requested neuron subtracts a drive term from its state. The drive term is built from how many other neurons are on in its row and in its column, weighted by A and B, offset by C/2, and scaled down by a programmable right shift. A neuron is on while its state is strictly positive. Neighbours in a row or a column suppress each other. A neuron that sits alone in its row and column grows until it saturates. This lets the array give up a greedy crosspoint in favour of two non-conflicting ones.

Iteration ends when one of two things happens. The first is that the array has reached a fixed point: the outputs did not change in the last step, no two on-neurons share a line, and no requested neuron sits idle with its row and column both empty. The second is that a programmable step limit is reached. A final resolve pass then produces the grant matrix. It first keeps on-neurons in row-major order, dropping conflicts. It then fills any requested crosspoint whose row and column are still free, again in row-major order. The result is always legal and maximal. A one-cycle `done` pulse presents the grant matrix and the step count.

Top module: `xbar_neural_sched`

## Requirements
- R1: After reset, `busy`, `done`, `grant` and `iter_count` are all zero.
- R2: On an accepted start, requested neurons load state C>>1 and unrequested neurons load -2048. With `max_iter` = 0, no step is taken, `iter_count` is 0, and the grant matrix is the resolve pass applied to the initial outputs.
- R3: A crosspoint whose request bit was 0 at start is never granted.
- R4: Each step replaces the state x of every requested neuron with sat(x - ((A·r + B·c - (C>>1)) >>> S)). Here r and c count the other on-neurons in its row and column, S is `step_shift`, and a neuron is on when x > 0. For requests {(1,1),(1,3),(3,1)} with A=B=64, C=192, S=2, the run ends after exactly 13 steps.
- R5: The run ends as soon as the last step changed no output, the on-set has no row or column conflict, and no requested off-neuron has an empty row and an empty column. A conflict-free request set therefore ends after 1 step.
- R6: The run never takes more than `max_iter` steps. A request set that never settles reports `iter_count` equal to `max_iter`.
- R7: The grant matrix holds at most one set bit per row (input) and per column (output).
- R8: The grant matrix is maximal. Every requested crosspoint that is not granted has a grant elsewhere in its row or its column. Ties are resolved in row-major order.
- R9: State arithmetic saturates at +2047 and -2048. An isolated requested neuron with C=4095 and S=0 stays on, so its run ends after 1 step.
- R10: A start pulse while `busy` is high is ignored. The running job completes unchanged and produces exactly one `done`.
- R11: `done` is high for exactly one cycle. `grant` and `iter_count` hold their values until the next job completes.
- R12: For requests {(1,1),(1,3),(3,1)}, the result has the maximum matching size of 2, granting (1,3) and (3,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job; accepted only when idle |
| req | input | N*N | Request matrix, bit i*N+j = input i wants output j |
| coef_a | input | 12 | Row inhibition weight A (unsigned) |
| coef_b | input | 12 | Column inhibition weight B (unsigned) |
| coef_c | input | 12 | Excitation constant C (unsigned) |
| step_shift | input | SW | Step size as a right-shift amount |
| max_iter | input | IW | Step limit per job |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse: result valid |
| grant | output | N*N | Grant matrix, same encoding as req |
| iter_count | output | IW | Steps taken by the last job |

## Verification
The hardest situation to reach from the ports is a run that never settles. Only a symmetric conflict can keep the array oscillating between all-on and all-off until the step limit. The bench builds one from two requests in a single row, with A larger than C/2, and expects the cap and the row-major fill to decide. The exact 13-step descent of the contested neuron in the three-request example gives a precise check of the update arithmetic. A lone neuron with C at full scale and no shift is the only way to make saturation visible at the ports: a wrapped state would turn it off and prolong the run.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  localparam int XW = 12;
  localparam int XMAX_I = (2 ** (XW - 1)) - 1;
  localparam int XMIN_I = -(2 ** (XW - 1));

  typedef logic signed [XW-1:0] state_t;
  typedef logic [XW-1:0] coef_t;

  localparam state_t X_MAX = state_t'(XMAX_I);
  localparam state_t X_MIN = state_t'(XMIN_I);

  // Scaled drive term: positive values push a neuron toward off.
  function automatic int drive_term(input int row_oth, input int col_oth,
                                    input coef_t a, input coef_t b,
                                    input coef_t c, input int shift);
    int d;
    d = int'(a) * row_oth + int'(b) * col_oth - int'(c >> 1);
    return d >>> shift;
  endfunction

  // Apply a drive term with saturation to the state range.
  function automatic state_t apply_drive(input state_t x, input int d);
    int n;
    n = int'(x) - d;
    if (n > XMAX_I) return X_MAX;
    if (n < XMIN_I) return X_MIN;
    return state_t'(n);
  endfunction

  function automatic state_t seed_state(input coef_t c);
    return state_t'({1'b0, c[XW-1:1]});
  endfunction
endpackage

// File: rtl/xbs_cell.sv
module xbs_cell
  import xbs_pkg::*;
#(
  parameter int CW = 5,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          req_bit,
  input  state_t        x_init,
  input  logic [CW-1:0] row_oth,
  input  logic [CW-1:0] col_oth,
  input  coef_t         a,
  input  coef_t         b,
  input  coef_t         c,
  input  logic [SW-1:0] shift,
  output logic          y
);
  logic   req_q;
  state_t x;
  state_t x_nxt;
  int     drv;
  logic   rising;  // the drive pushes the state upward this step

  always_comb begin
    drv   = drive_term(int'(row_oth), int'(col_oth), a, b, c, int'(shift));
    x_nxt = apply_drive(x, drv);
  end
  assign rising = (drv < 0);
  assign y      = (x > 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      x     <= X_MIN;
    end else if (load) begin
      req_q <= req_bit;
      x     <= req_bit ? x_init : X_MIN;
    end else if (step && req_q) begin
      x <= x_nxt;
    end
  end

  // R3: a crosspoint without a request never lights
  a_r3_unreq_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |-> !y);
  // R9: an on-neuron being driven upward must not wrap to off
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && req_q && y && rising) |=> y);
endmodule

// File: rtl/xbs_resolve.sv
module xbs_resolve #(
  parameter int N = 16
) (
  input  logic [N*N-1:0] on,
  input  logic [N*N-1:0] req,
  output logic [N*N-1:0] keep
);
  logic [N-1:0] row_busy;
  logic [N-1:0] col_busy;

  // Pass 0 keeps on-neurons, pass 1 fills free requested crosspoints.
  always_comb begin
    row_busy = '0;
    col_busy = '0;
    keep     = '0;
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (((p == 0) ? on[i*N+j] : req[i*N+j]) && !row_busy[i] && !col_busy[j]) begin
            keep[i*N+j] = 1'b1;
            row_busy[i] = 1'b1;
            col_busy[j] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/xbs_ctrl.sv
module xbs_ctrl #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          settled,
  input  logic [IW-1:0] max_iter,
  output logic          load,
  output logic          step,
  output logic          capture,
  output logic          busy,
  output logic [IW-1:0] iter
);
  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FIN} phase_t;

  phase_t        ph;
  logic [IW-1:0] cap_q;
  logic          stop;

  assign stop    = settled || (iter >= cap_q);
  assign load    = (ph == PH_IDLE) && start;
  assign step    = (ph == PH_RUN) && !stop;
  assign capture = (ph == PH_RUN) && stop;
  assign busy    = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      iter  <= '0;
      cap_q <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph    <= PH_RUN;
          iter  <= '0;
          cap_q <= max_iter;
        end
        PH_RUN: begin
          if (stop) ph <= PH_FIN;
          else      iter <= iter + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R6: the step count never passes the latched limit
  a_r6_iter_cap: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (iter <= cap_q));
  // R4: each step advances the count by one
  a_r4_step_count: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (iter == $past(iter) + 1'b1));
endmodule

// File: rtl/xbar_neural_sched.sv
module xbar_neural_sched
  import xbs_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [N*N-1:0] req,
  input  logic [XW-1:0] coef_a,
  input  logic [XW-1:0] coef_b,
  input  logic [XW-1:0] coef_c,
  input  logic [SW-1:0] step_shift,
  input  logic [IW-1:0] max_iter,
  output logic          busy,
  output logic          done,
  output logic [N*N-1:0] grant,
  output logic [IW-1:0] iter_count
);
  localparam int NN = N * N;
  localparam int CW = $clog2(N + 1);

  logic          load, step, capture, settled;
  logic [IW-1:0] iter;
  logic [NN-1:0] y, y_prev, req_q, keep;
  logic          prev_ok;
  coef_t         a_q, b_q, c_q;
  logic [SW-1:0] sh_q;
  state_t        x_init;
  logic [CW-1:0] row_tot [N];
  logic [CW-1:0] col_tot [N];
  logic          legal, open_slot, moved;

  assign x_init = seed_state(coef_c);

  // Line occupancy of the current outputs
  always_comb begin
    for (int k = 0; k < N; k++) begin
      row_tot[k] = '0;
      col_tot[k] = '0;
    end
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (y[i*N+j]) begin
          row_tot[i] = row_tot[i] + CW'(1);
          col_tot[j] = col_tot[j] + CW'(1);
        end
      end
    end
  end

  // Fixed-point detector
  always_comb begin
    legal     = 1'b1;
    open_slot = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (row_tot[k] > CW'(1) || col_tot[k] > CW'(1)) legal = 1'b0;
    end
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (req_q[i*N+j] && !y[i*N+j] && row_tot[i] == '0 && col_tot[j] == '0)
          open_slot = 1'b1;
      end
    end
  end
  assign moved   = !prev_ok || (y != y_prev);
  assign settled = !moved && legal && !open_slot;

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      xbs_cell #(.CW(CW), .SW(SW)) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .req_bit (req[gi*N+gj]),
        .x_init  (x_init),
        .row_oth (row_tot[gi] - CW'(y[gi*N+gj])),
        .col_oth (col_tot[gj] - CW'(y[gi*N+gj])),
        .a       (a_q),
        .b       (b_q),
        .c       (c_q),
        .shift   (sh_q),
        .y       (y[gi*N+gj])
      );
    end
  end

  xbs_resolve #(.N(N)) u_resolve (
    .on   (y),
    .req  (req_q),
    .keep (keep)
  );

  xbs_ctrl #(.IW(IW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .settled  (settled),
    .max_iter (max_iter),
    .load     (load),
    .step     (step),
    .capture  (capture),
    .busy     (busy),
    .iter     (iter)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= '0;
      a_q        <= '0;
      b_q        <= '0;
      c_q        <= '0;
      sh_q       <= '0;
      y_prev     <= '0;
      prev_ok    <= 1'b0;
      done       <= 1'b0;
      grant      <= '0;
      iter_count <= '0;
    end else begin
      done <= capture;
      if (load) begin
        req_q   <= req;
        a_q     <= coef_a;
        b_q     <= coef_b;
        c_q     <= coef_c;
        sh_q    <= step_shift;
        prev_ok <= 1'b0;
      end
      if (step) begin
        y_prev  <= y;
        prev_ok <= 1'b1;
      end
      if (capture) begin
        grant      <= keep;
        iter_count <= iter;
      end
    end
  end

  // Column view of the grant matrix for the legality checks
  logic [N-1:0] gcol [N];
  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        gcol[j][i] = grant[i*N+j];
  end

  for (genvar k = 0; k < N; k++) begin : g_legal
    // R7: one grant per input and per output
    a_r7_row_one: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $onehot0(grant[k*N +: N]));
    a_r7_col_one: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $onehot0(gcol[k]));
  end

  // R3: grants only where a request was latched
  a_r3_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((grant & ~req_q) == '0));
  // R10: the latched request is frozen while a job runs
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(req_q));
  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/xbar_neural_sched_tb.sv
module xbar_neural_sched_tb;
  localparam int BN = 4;
  localparam int BNN = BN * BN;

  typedef struct {
    logic [BNN-1:0] req;
    int             exp_iter;
    logic [BNN-1:0] exp_grant;
    bit             chk_grant;
    bit             chk_best;
    string          tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [BNN-1:0]  req = '0;
  logic [11:0]     coef_a = '0, coef_b = '0, coef_c = '0;
  logic [3:0]      step_shift = '0;
  logic [7:0]      max_iter = '0;
  logic            busy, done;
  logic [BNN-1:0]  grant;
  logic [7:0]      iter_count;

  int    n_checks = 0;
  int    n_fails = 0;
  item_t sb_q[$];

  always #4 clk = ~clk;

  xbar_neural_sched #(.N(BN), .IW(8), .SW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .step_shift(step_shift), .max_iter(max_iter),
    .busy(busy), .done(done), .grant(grant), .iter_count(iter_count)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [BNN-1:0] g);
    int n = 0;
    for (int k = 0; k < BNN; k++) n += int'(g[k]);
    return n;
  endfunction

  function automatic bit is_legal(input logic [BNN-1:0] g);
    for (int k = 0; k < BN; k++) begin
      int r = 0;
      int c = 0;
      for (int m = 0; m < BN; m++) begin
        r += int'(g[k*BN+m]);
        c += int'(g[m*BN+k]);
      end
      if (r > 1 || c > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit is_maximal(input logic [BNN-1:0] g, input logic [BNN-1:0] r);
    for (int i = 0; i < BN; i++)
      for (int j = 0; j < BN; j++)
        if (r[i*BN+j] && !g[i*BN+j]) begin
          bit hit = 1'b0;
          for (int m = 0; m < BN; m++)
            if (g[i*BN+m] || g[m*BN+j]) hit = 1'b1;
          if (!hit) return 1'b0;
        end
    return 1'b1;
  endfunction

  // Brute-force maximum matching: each row picks a column or none.
  function automatic int best_size(input logic [BNN-1:0] r);
    int best = 0;
    for (int code = 0; code < 625; code++) begin
      int v = code;
      int used = 0;
      int cnt = 0;
      bit ok = 1'b1;
      for (int i = 0; i < BN; i++) begin
        int pick = v % 5;
        v = v / 5;
        if (pick != 0) begin
          if (!r[i*BN+pick-1] || used[pick-1]) ok = 1'b0;
          used[pick-1] = 1'b1;
          cnt++;
        end
      end
      if (ok && cnt > best) best = cnt;
    end
    return best;
  endfunction

  task automatic run_case(input logic [BNN-1:0] r, input int a, input int b,
                          input int c, input int sh, input int mx,
                          input int ei, input logic [BNN-1:0] eg,
                          input bit cg, input bit cb, input bit poke,
                          input string tg);
    item_t it;
    it.req = r; it.exp_iter = ei; it.exp_grant = eg;
    it.chk_grant = cg; it.chk_best = cb; it.tag = tg;
    sb_q.push_back(it);
    @(negedge clk);
    req = r; coef_a = 12'(a); coef_b = 12'(b); coef_c = 12'(c);
    step_shift = 4'(sh); max_iter = 8'(mx);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: a second start mid-run with a different request
      @(negedge clk);
      req = '1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      req = r;
    end
    while (sb_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on each completed job
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R10 unexpected done", 64'(grant), 64'(0));
        end else begin
          item_t it;
          logic [BNN-1:0] held;
          it = sb_q.pop_front();
          check(is_legal(grant), {it.tag, " R7 legal"}, 64'(grant), 64'(0));
          check((grant & ~it.req) == '0, {it.tag, " R3 subset"}, 64'(grant), 64'(it.req));
          check(is_maximal(grant, it.req), {it.tag, " R8 maximal"}, 64'(grant), 64'(it.req));
          if (it.exp_iter >= 0)
            check(int'(iter_count) == it.exp_iter, {it.tag, " steps"},
                  64'(iter_count), 64'(it.exp_iter));
          if (it.chk_grant)
            check(grant == it.exp_grant, {it.tag, " grant"}, 64'(grant), 64'(it.exp_grant));
          if (it.chk_best)
            check(popc(grant) == best_size(it.req), {it.tag, " R12 max size"},
                  64'(popc(grant)), 64'(best_size(it.req)));
          held = grant;
          @(negedge clk);
          check(!done && grant == held, "R11 pulse and hold", 64'(grant), 64'(held));
        end
      end
    end
  end

  task automatic finish_up;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 64'(0), 64'(1));
    finish_up();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && grant == '0 && iter_count == '0,
          "R1 reset state", 64'({busy, done, grant, iter_count}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 idle after reset", 64'({busy, done}), 64'(0));

    // empty and conflict-free requests settle after one step
    run_case(16'h0000, 64, 64, 192, 2, 60, 1, 16'h0000, 1, 1, 0, "R5 empty");
    run_case(16'h8421, 64, 64, 192, 2, 60, 1, 16'h8421, 1, 1, 0, "R5 diagonal");
    // three-request example, no steps: resolve keeps (1,1) only
    run_case(16'h20A0, 64, 64, 192, 2, 0, 0, 16'h0020, 1, 0, 0, "R2 no steps");
    // same example evolved: contested neuron decays 96 -> 0 in 12 steps, 13th confirms
    run_case(16'h20A0, 64, 64, 192, 2, 60, 13, 16'h2080, 1, 1, 0, "R4 example");
    // symmetric row pair oscillates until the cap; fill picks (0,0)
    run_case(16'h0003, 64, 64, 96, 2, 20, 20, 16'h0001, 1, 1, 0, "R6 cap");
    // lone neuron at full-scale C must saturate, not wrap
    run_case(16'h0001, 64, 64, 4095, 0, 30, 1, 16'h0001, 1, 1, 0, "R9 saturate");
    // all requests: resolve gives a perfect matching
    run_case(16'hFFFF, 64, 64, 192, 2, 40, -1, 16'h0000, 0, 1, 0, "R8 full");
    // start while busy must be ignored
    run_case(16'h20A0, 64, 64, 192, 2, 60, 13, 16'h2080, 1, 1, 1, "R10 busy start");

    lfsr = 16'hACE1;
    for (int t = 0; t < 6; t++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_case(lfsr, 64, 64, 192, 2, 40, -1, 16'h0000, 0, 0, 0, "R7 random");
    end
    finish_up();
  end
endmodule